// File: doc/BRIEF.md
# Multicast hash address filter

This block decides, frame by frame, whether a receive path keeps or drops an incoming frame, based on the 48-bit destination address. An individual (unicast) address is kept only when it equals the programmed station address. A group address can be passed wholesale, or looked up in a 256-bit hash table. The table index comes from a reflected CRC-32 over the address. A promiscuous setting keeps everything. The all-ones broadcast address is always kept.

The address arrives on `dst_addr_i` together with a one-cycle strobe `dst_valid_i`. Byte 0, the first byte on the wire, sits in bits 7:0, and each byte is sent least significant bit first. Two cycles later `accept_valid_o` pulses for one cycle, and `accept_o` carries the verdict. Software programs the block through a simple write port. Word addresses 0 to 7 are the hash words. Address 8 is the station address low word, address 9 is the station address high word, and address 10 is the mode word. Writes to any other address are dropped.

Top module: `mcast_hash_filter`

## Requirements
- R1: A unicast address (bit 0 of byte 0 clear) that equals the station address is accepted. Register 8 holds bytes 0..3, with byte 0 in bits 7:0. Register 9 holds bytes 4..5 in bits 15:0.
- R2: A unicast address that differs from the station address is rejected when promiscuous mode is off, whatever the hash table and the group modes hold.
- R3: With mode bit 0 (promiscuous) set, every address is accepted.
- R4: With mode bit 1 (pass all group) set, every group address (bit 0 of byte 0 set) is accepted, even where its hash bit is clear.
- R5: With mode bit 2 (hash group) set and bit 1 clear, a group address is accepted exactly when its hash bit is set. To form the index, run a CRC-32 over the six bytes in wire order, LSB first, with reflected polynomial 0xEDB88320, initial value all ones and no final inversion. Invert the low byte of the result and bit-reverse it. Bits 7:5 of the index pick the hash word (register 0..7) and bits 4:0 pick the bit within that word.
- R6: A group address that is not broadcast is rejected when mode bits 1 and 2 are both clear.
- R7: The address FF:FF:FF:FF:FF:FF is accepted in every mode.
- R8: `accept_valid_o` is high for exactly one cycle, two clock edges after each `dst_valid_i` strobe. Back-to-back strobes give back-to-back results in the same order. There is no pulse without a strobe.
- R9: After reset `accept_valid_o` and `accept_o` are low, and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Register write data |
| dst_addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| dst_valid_i | input | 1 | Address strobe |
| accept_valid_o | output | 1 | Verdict strobe |
| accept_o | output | 1 | 1 keeps the frame, 0 drops it |

## Verification
Each verdict is due in the cycle after the second rising edge that follows the strobe. The address is captured by the parse stage on the first edge, and the verdict register loads on the second. The bench drives on falling edges. It checks that `accept_valid_o` is still low after the first edge, checks the verdict after the second, and checks that the strobe is gone after the third. A register write takes effect on the edge after it is driven, so every lookup follows its setup writes by at least one full cycle. The back-to-back case checks two verdicts in consecutive cycles.

// File: rtl/mhf_pkg.sv
`timescale 1ns/1ps
package mhf_pkg;
  localparam int unsigned MAC_W      = 48;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned HASH_W     = 8;
  localparam int unsigned BSEL_W     = $clog2(REG_W);
  localparam int unsigned WSEL_W     = HASH_W - BSEL_W;
  localparam int unsigned HASH_WORDS = 1 << WSEL_W;
  localparam int unsigned TBL_W      = HASH_WORDS * REG_W;
  localparam int unsigned RADDR_W    = 4;
  localparam logic [RADDR_W-1:0] RA_STA_LO = RADDR_W'(HASH_WORDS);
  localparam logic [RADDR_W-1:0] RA_STA_HI = RADDR_W'(HASH_WORDS + 1);
  localparam logic [RADDR_W-1:0] RA_MODE   = RADDR_W'(HASH_WORDS + 2);
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef struct packed {
    logic hash_grp;
    logic pass_grp;
    logic promisc;
  } mode_t;

  typedef struct packed {
    logic [HASH_W-1:0] idx;
    logic              grp;
    logic              bcast;
    logic              sta_hit;
  } parsed_t;

  // reflected crc over the address, LSB of byte 0 first; returns hash index
  function automatic logic [HASH_W-1:0] hash_index(input logic [MAC_W-1:0] a);
    logic [31:0] c;
    logic        fb;
    logic [HASH_W-1:0] h;
    c = '1;
    for (int i = 0; i < MAC_W; i++) begin
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    for (int j = 0; j < HASH_W; j++) h[j] = ~c[HASH_W-1-j];
    return h;
  endfunction
endpackage

// File: rtl/mhf_regs.sv
`timescale 1ns/1ps
module mhf_regs
  import mhf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [RADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [TBL_W-1:0]   hash_tbl_o,
  output logic [MAC_W-1:0]   sta_addr_o,
  output mode_t              mode_o
);
  localparam int unsigned HI_W = MAC_W - REG_W;

  for (genvar g = 0; g < HASH_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hash_tbl_o[g*REG_W +: REG_W] <= '0;
      else if (wr_en_i && wr_addr_i == RADDR_W'(g))
        hash_tbl_o[g*REG_W +: REG_W] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_addr_o <= '0;
      mode_o     <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == RA_STA_LO) sta_addr_o[REG_W-1:0] <= wr_data_i;
      if (wr_addr_i == RA_STA_HI) sta_addr_o[MAC_W-1:REG_W] <= wr_data_i[HI_W-1:0];
      if (wr_addr_i == RA_MODE)   mode_o <= mode_t'(wr_data_i[$bits(mode_t)-1:0]);
    end
  end

  AST_MODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == RA_MODE) |=> (mode_o.promisc == $past(wr_data_i[0]))); // R3
endmodule

// File: rtl/mhf_parse.sv
`timescale 1ns/1ps
module mhf_parse
  import mhf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAC_W-1:0] dst_addr_i,
  input  logic             dst_valid_i,
  input  logic [MAC_W-1:0] sta_addr_i,
  output parsed_t          parsed_o,
  output logic             valid_o
);
  parsed_t p_d;

  always_comb begin
    p_d.idx     = hash_index(dst_addr_i);
    p_d.grp     = dst_addr_i[0];
    p_d.bcast   = &dst_addr_i;
    p_d.sta_hit = (dst_addr_i == sta_addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      parsed_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= dst_valid_i;
      if (dst_valid_i) parsed_o <= p_d;
    end
  end
endmodule

// File: rtl/mhf_decide.sv
`timescale 1ns/1ps
module mhf_decide
  import mhf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  parsed_t          parsed_i,
  input  logic [TBL_W-1:0] hash_tbl_i,
  input  mode_t            mode_i,
  output logic             accept_valid_o,
  output logic             accept_o
);
  logic hash_bit;
  logic verdict;

  // word w bit b sits at w*REG_W+b, which equals the index itself
  assign hash_bit = hash_tbl_i[parsed_i.idx];

  always_comb begin
    if (mode_i.promisc || parsed_i.bcast) verdict = 1'b1;
    else if (parsed_i.grp)                verdict = mode_i.pass_grp || (mode_i.hash_grp && hash_bit);
    else                                  verdict = parsed_i.sta_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_valid_o <= 1'b0;
      accept_o       <= 1'b0;
    end else begin
      accept_valid_o <= valid_i;
      accept_o       <= valid_i && verdict;
    end
  end

  AST_PROMISC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i.promisc) |=> accept_o); // R3
  AST_BCAST_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && parsed_i.bcast) |=> accept_o); // R7
  AST_UCAST_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !parsed_i.grp && !parsed_i.sta_hit && !mode_i.promisc) |=> !accept_o); // R2
endmodule

// File: rtl/mcast_hash_filter.sv
`timescale 1ns/1ps
module mcast_hash_filter
  import mhf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [RADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [MAC_W-1:0]   dst_addr_i,
  input  logic               dst_valid_i,
  output logic               accept_valid_o,
  output logic               accept_o
);
  logic [TBL_W-1:0] hash_tbl;
  logic [MAC_W-1:0] sta_addr;
  mode_t            mode;
  parsed_t          parsed;
  logic             parsed_vld;

  mhf_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .hash_tbl_o(hash_tbl), .sta_addr_o(sta_addr), .mode_o(mode)
  );

  mhf_parse u_parse (
    .clk_i, .rst_ni, .dst_addr_i, .dst_valid_i,
    .sta_addr_i(sta_addr), .parsed_o(parsed), .valid_o(parsed_vld)
  );

  mhf_decide u_decide (
    .clk_i, .rst_ni, .valid_i(parsed_vld), .parsed_i(parsed),
    .hash_tbl_i(hash_tbl), .mode_i(mode),
    .accept_valid_o, .accept_o
  );

  AST_VERDICT_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_i |-> ##2 accept_valid_o); // R8
  AST_NO_STRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_valid_o |-> $past(dst_valid_i, 2)); // R8
  AST_QUIET_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_valid_o |-> !accept_o); // R9
endmodule

// File: tb/mcast_hash_filter_tb.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [47:0] dst_addr_i = '0;
  logic        dst_valid_i = 1'b0;
  logic        accept_valid_o;
  logic        accept_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  mcast_hash_filter u_dut (.*);

  localparam logic [47:0] STA   = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
  localparam logic [47:0] OTHER = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h04};
  localparam logic [47:0] GRP_A = {8'h01, 8'h00, 8'h00, 8'h5e, 8'h00, 8'h01};
  localparam logic [47:0] BCAST = '1;

  function automatic logic [7:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  v;
    logic [7:0]  r;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      v = a[8*b +: 8];
      for (int k = 0; k < 8; k++) begin
        if ((c[0] ^ v[0]) == 1'b1) c = (c >> 1) ^ 32'hEDB8_8320;
        else c = c >> 1;
        v = v >> 1;
      end
    end
    for (int k = 0; k < 8; k++) r[k] = ~c[7-k];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_table();
    for (int w = 0; w < 8; w++) wr(4'(w), 32'h0);
  endtask

  // strobe one address and check the verdict at its due cycle
  task automatic lookup(input string req, input logic [47:0] a, input logic exp);
    @(negedge clk_i);
    dst_addr_i = a; dst_valid_i = 1'b1;
    @(negedge clk_i);
    dst_valid_i = 1'b0;
    chk({req, " early"}, 32'(accept_valid_o), 32'h0);
    @(negedge clk_i);
    chk({req, " valid"}, 32'(accept_valid_o), 32'h1);
    chk({req, " verdict"}, 32'(accept_o), 32'(exp));
    @(negedge clk_i);
    chk({req, " pulse"}, 32'(accept_valid_o), 32'h0);
  endtask

  task automatic t_reset();
    chk("R9 reset valid", 32'(accept_valid_o), 32'h0);
    chk("R9 reset verdict", 32'(accept_o), 32'h0);
    lookup("R9 zero mode group", GRP_A, 1'b0);
  endtask

  task automatic t_unicast();
    wr(4'd8, STA[31:0]);
    wr(4'd9, {16'h0, STA[47:32]});
    wr(4'd10, 32'h0);
    lookup("R1 station hit", STA, 1'b1);
    lookup("R2 station miss", OTHER, 1'b0);
    wr(4'd10, 32'h6);
    for (int w = 0; w < 8; w++) wr(4'(w), 32'hFFFF_FFFF);
    lookup("R2 miss with group modes", OTHER, 1'b0);
    clear_table();
  endtask

  task automatic t_promisc();
    wr(4'd10, 32'h1);
    lookup("R3 unicast miss", OTHER, 1'b1);
    lookup("R3 group", GRP_A, 1'b1);
  endtask

  task automatic t_passall();
    wr(4'd10, 32'h6);
    lookup("R4 pass all clear bit", GRP_A, 1'b1);
    lookup("R4 pass all other group", GRP_A ^ 48'h0000_0000_ff00, 1'b1);
  endtask

  task automatic t_nogroup();
    wr(4'd10, 32'h0);
    lookup("R6 group no mode", GRP_A, 1'b0);
  endtask

  task automatic t_hash();
    logic [7:0]  ia;
    logic [7:0]  ib;
    logic [47:0] gb;
    ia = ref_idx(GRP_A);
    gb = GRP_A;
    do begin
      gb[47:40] = gb[47:40] + 8'd1;
      ib = ref_idx(gb);
    end while (ib == ia);
    wr(4'd10, 32'h4);
    lookup("R5 bit clear", GRP_A, 1'b0);
    wr(4'(ia[7:5]), 32'h1 << ia[4:0]);
    lookup("R5 bit set", GRP_A, 1'b1);
    lookup("R5 other index", gb, 1'b0);
    wr(4'(ia[7:5]), 32'h0);
    wr(4'(ib[7:5]), 32'h1 << ib[4:0]);
    lookup("R5 moved bit", gb, 1'b1);
    lookup("R5 moved bit old addr", GRP_A, 1'b0);
    clear_table();
  endtask

  task automatic t_bcast();
    wr(4'd10, 32'h0);
    lookup("R7 bcast mode 0", BCAST, 1'b1);
    wr(4'd10, 32'h4);
    lookup("R7 bcast empty table", BCAST, 1'b1);
  endtask

  task automatic t_b2b();
    wr(4'd10, 32'h0);
    @(negedge clk_i);
    dst_addr_i = STA; dst_valid_i = 1'b1;
    @(negedge clk_i);
    dst_addr_i = OTHER;
    chk("R8 b2b early", 32'(accept_valid_o), 32'h0);
    @(negedge clk_i);
    dst_valid_i = 1'b0;
    chk("R8 b2b first valid", 32'(accept_valid_o), 32'h1);
    chk("R8 b2b first verdict", 32'(accept_o), 32'h1);
    @(negedge clk_i);
    chk("R8 b2b second valid", 32'(accept_valid_o), 32'h1);
    chk("R8 b2b second verdict", 32'(accept_o), 32'h0);
    @(negedge clk_i);
    chk("R8 b2b end", 32'(accept_valid_o), 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_unicast();
    t_promisc();
    t_passall();
    t_nogroup();
    t_hash();
    t_bcast();
    t_b2b();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule